// File: doc/BRIEF.md
# Four-Code Skipping Sequence Counter

This block is a free-running 3-bit synchronous counter. Its loop has four codes in a fixed order that is not binary: 000, then 001, then 010, then 100, and then back to 000. The other four codes (011, 101, 110, 111) never appear in normal operation. The counter has no data or enable input. It moves to a new code on every clock edge and never holds a code.

Each state bit is a toggle flop: a toggle input of 1 inverts the bit and 0 keeps it. The toggle inputs come from a next-code function that also covers the four skipped codes. If the state is upset into one of them, the counter rejoins the loop on the next clock edge with no reset. A wrap pulse is high for the single cycle in which the count is 100, so it marks the last code of each pass. A parameter sets the code loaded by reset. Its default is 000, and a non-default value lets a test start the counter from a skipped code.

Top module: `skip_cnt`

## Requirements
- R1: While rst_ni is low, count_o is the reset code (000 by default). Reset acts asynchronously, without waiting for a clock edge.
- R2: From 000 the count goes to 001 on the next rising clock edge.
- R3: From 001 the count goes to 010 on the next rising clock edge.
- R4: From 010 the count goes to 100 on the next rising clock edge.
- R5: From 100 the count goes to 000 on the next rising clock edge, which closes the loop.
- R6: Out of reset, the count changes on every rising edge. It never holds, and it repeats with a period of exactly four clocks.
- R7: The skipped code 011 goes to 100 in one clock.
- R8: The skipped codes 101, 110 and 111 go to 000 in one clock.
- R9: wrap_o is 1 exactly in the cycles where count_o is 100, so it is a one-cycle pulse once every four clocks.
- R10: The parameter RST_CODE sets the code loaded by reset, and it may be a skipped code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, loads RST_CODE |
| count_o | output | 3 | Current counter code |
| wrap_o | output | 1 | High while count_o is 100 |

## Verification
The bench follows the loop over many passes. A design that counts in binary, or that holds a code for a cycle, would show 011 after 010 or a repeated value. Four extra instances start from each skipped code. A next-code function that leaves a skipped code unhandled would stay stuck there, or would land on a loop code other than 100 or 000. The bench also checks that wrap_o lines up with 100 and falls after one cycle, and that a reset asserted between clock edges clears the count at once.

// File: rtl/skip_cnt_pkg.sv
package skip_cnt_pkg;
  localparam int unsigned CntW = 3;
  typedef logic [CntW-1:0] code_t;

  localparam code_t CodeA = 3'b000;
  localparam code_t CodeB = 3'b001;
  localparam code_t CodeC = 3'b010;
  localparam code_t CodeD = 3'b100;

  // loop order plus recovery of skipped codes
  function automatic code_t next_code(input code_t cur);
    code_t nxt;
    case (cur)
      CodeA:   nxt = CodeB;
      CodeB:   nxt = CodeC;
      CodeC:   nxt = CodeD;
      3'b011:  nxt = CodeD;
      default: nxt = CodeA;
    endcase
    return nxt;
  endfunction
endpackage

// File: rtl/skip_cnt_toggle.sv
module skip_cnt_toggle
  import skip_cnt_pkg::*;
(
  input  code_t cur_i,
  output code_t tgl_o
);
  // a bit toggles where next and current differ
  assign tgl_o = cur_i ^ next_code(cur_i);
endmodule

// File: rtl/skip_cnt_tff.sv
module skip_cnt_tff #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic t_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else if (t_i) q_o <= ~q_o;
  end
endmodule

// File: rtl/skip_cnt.sv
module skip_cnt
  import skip_cnt_pkg::*;
#(
  parameter code_t RST_CODE = CodeA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CntW-1:0]  count_o,
  output logic             wrap_o
);
  code_t state_q;
  code_t tgl;

  skip_cnt_toggle u_tgl (
    .cur_i (state_q),
    .tgl_o (tgl)
  );

  for (genvar b = 0; b < CntW; b++) begin : g_bit
    skip_cnt_tff #(.RST_VAL(RST_CODE[b])) u_ff (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .t_i    (tgl[b]),
      .q_o    (state_q[b])
    );
  end

  assign count_o = state_q;
  assign wrap_o  = (state_q == CodeD);
endmodule

module skip_cnt_chk
  import skip_cnt_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [CntW-1:0] count_i,
  input logic            wrap_i
);
  // R2
  step_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i == 3'b000 |=> count_i == 3'b001);
  // R3
  step_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i == 3'b001 |=> count_i == 3'b010);
  // R4
  step_c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i == 3'b010 |=> count_i == 3'b100);
  // R5
  step_d_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i == 3'b100 |=> count_i == 3'b000);
  // R6
  no_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> count_i != $past(count_i));
  // R7
  fix_three_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i == 3'b011 |=> count_i == 3'b100);
  // R8
  fix_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == 3'b101 || count_i == 3'b110 || count_i == 3'b111) |=> count_i == 3'b000);
  // R9
  wrap_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (!wrap_i && count_i == 3'b000));
endmodule

bind skip_cnt skip_cnt_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .count_i (count_o),
  .wrap_i  (wrap_o)
);

// File: tb/sim_skip_cnt.sv
`timescale 1ns/1ps
module sim_skip_cnt;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] cnt;
  logic wrap;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  skip_cnt u0 (.clk_i(clk), .rst_ni(rst_ni), .count_o(cnt), .wrap_o(wrap));

  logic [2:0] f_cnt [4];
  logic       f_wrap [4];
  for (genvar g = 0; g < 4; g++) begin : g_flt
    localparam logic [2:0] C = (g == 0) ? 3'b011 : (g == 1) ? 3'b101 :
                               (g == 2) ? 3'b110 : 3'b111;
    skip_cnt #(.RST_CODE(C)) u_f (.clk_i(clk), .rst_ni(rst_ni),
                                  .count_o(f_cnt[g]), .wrap_o(f_wrap[g]));
  end

  typedef struct { logic [2:0] code; logic wrp; } exp_t;
  exp_t exp_q[$];
  logic [2:0] model = 3'b000;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_loop(input int n);
    for (int i = 0; i < n; i++) begin
      case (model)
        3'b000:  model = 3'b001;
        3'b001:  model = 3'b010;
        3'b010:  model = 3'b100;
        default: model = 3'b000;
      endcase
      exp_q.push_back('{code: model, wrp: (model == 3'b100)});
    end
  endtask

  // monitor: one expected item per cycle after reset release
  initial begin
    logic [2:0] prev;
    prev = 3'b000;
    wait (rst_ni);
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0 && rst_ni) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cnt == e.code, "R2-R5 sequence", cnt, e.code);
        chk(cnt != prev, "R6 no hold", cnt, e.code);
        chk(wrap == e.wrp, "R9 wrap", wrap, e.wrp);
        prev = cnt;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cnt == 3'b000, "R1 reset code", cnt, 0);
    chk(wrap == 1'b0, "R9 wrap in reset", wrap, 0);
    chk(f_cnt[0] == 3'b011, "R10 reset to 011", f_cnt[0], 3);
    chk(f_cnt[3] == 3'b111, "R10 reset to 111", f_cnt[3], 7);
    drive_loop(40);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(f_cnt[0] == 3'b100, "R7 011 recovery", f_cnt[0], 4);
    chk(f_wrap[0] == 1'b1, "R9 wrap after 011", f_wrap[0], 1);
    for (int k = 1; k < 4; k++)
      chk(f_cnt[k] == 3'b000, "R8 skipped code recovery", f_cnt[k], 0);
    @(negedge clk);
    chk(f_cnt[0] == 3'b000, "R5 after 011 recovery", f_cnt[0], 0);
    for (int k = 1; k < 4; k++)
      chk(f_cnt[k] == 3'b001, "R2 after recovery", f_cnt[k], 1);
    wait (exp_q.size() == 0);
    @(negedge clk);
    // count is now past 000; reset between edges must clear at once
    #1 rst_ni = 1'b0;
    #1 chk(cnt == 3'b000, "R1 async reset", cnt, 0);
    chk(f_cnt[1] == 3'b101, "R10 async reset code", f_cnt[1], 5);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule